// File: doc/BRIEF.md
# Barrel Shifter With Carry-Out

This block is the operand shifter of a RISC datapath. It takes a 32-bit operand, a two-bit shift kind, a shift amount, an amount-source select and the current carry flag. It returns the shifted operand and the carry-out that the shift produces. The instruction decoder drives it, and the carry-out feeds the flag logic whenever the instruction does not take its carry from the ALU.

Two sources of amount are supported. An amount encoded in the instruction uses five bits, and a zero in that field stands for a special case. An amount read from a register uses eight bits, and it has its own rules for zero and for amounts of 32 or more. The shift itself is built from a logarithmic right-shift network. Left shifts are done by bit reversal. The corner cases are settled by a small decoder placed ahead of the network.

A parameter adds an optional output register for timing, and it is on by default. With the register on, the outputs follow the inputs after one rising clock edge. There is no handshake: a new operation may be presented every cycle.

Top module: `shf_barrel_unit`

## Requirements
- R1: `kind_i` selects the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. `use_reg_i`=0 selects an immediate amount, which uses only `amt_i[4:0]`; bits 7:5 have no effect on either output. `use_reg_i`=1 selects a register amount, which uses all of `amt_i[7:0]`.
- R2: For an immediate amount n in 1..31:
  - a left shift gives `in<<n` with carry-out `in[32-n]`;
  - a logical right shift gives `in>>n` with carry-out `in[n-1]`;
  - an arithmetic right shift fills the vacated bits with `in[31]` and gives carry-out `in[n-1]`;
  - a rotate gives `in` rotated right by n with carry-out `in[n-1]`.
- R3: An immediate left shift with amount 0 passes the operand through unchanged, and the carry-out equals `cin_i`.
- R4: An immediate logical or arithmetic right shift with amount 0 acts as a shift by 32. The logical shift gives 0. The arithmetic shift gives every bit equal to `in[31]`. Both give carry-out `in[31]`.
- R5: An immediate rotate with amount 0 rotates right by one bit through the carry. The result is `{cin_i, in[31:1]}` and the carry-out is `in[0]`.
- R6: A register amount of 0, with any kind, passes the operand through unchanged, and the carry-out equals `cin_i`.
- R7: A register amount n in 1..31 behaves exactly as in R2, for all four kinds.
- R8: A register amount of exactly 32 makes a left or logical right shift give 0. The carry-out is `in[0]` for a left shift and `in[31]` for a logical right shift.
- R9: A register amount from 33 to 255 makes a left or logical right shift give 0, with carry-out 0.
- R10: A register amount of 32 or more makes an arithmetic right shift give every bit equal to `in[31]`, with carry-out `in[31]`.
- R11: A register rotate uses the amount modulo 32. A nonzero amount whose low five bits are zero gives the operand unchanged, with carry-out `in[31]`.
- R12: With the output register on (the default), the outputs show the result for the inputs present at the previous rising clock edge. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| opnd_i | input | 32 | Operand to shift |
| kind_i | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| use_reg_i | input | 1 | 0 = immediate amount, 1 = register amount |
| amt_i | input | 8 | Shift amount |
| cin_i | input | 1 | Current carry flag |
| res_o | output | 32 | Shifted operand |
| cout_o | output | 1 | Shifter carry-out |

## Verification
The assertions compare the combinational result against the inputs at each rising edge. They therefore assume that the inputs are free of X and are stable around that edge. Every two-bit kind value is legal, so no assumption is made about the kind. The stimulus changes every input only on the falling edge, and it holds reset low until the inputs carry defined values. Random amounts are drawn mostly from the boundary values 0, 1, 31, 32 and 33, multiples of 32, and 255, with occasional fully random bytes.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int SHF_W     = 32;
  localparam int SHF_AMT_W = 8;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic hold;      // pass operand, carry from flag
    logic rrx;       // one-bit rotate through carry
    logic zero_all;  // result and carry both zero
  } shf_special_t;

endpackage

// File: rtl/shf_amt_decode.sv
module shf_amt_decode
  import shf_pkg::*;
#(
  parameter int W     = SHF_W,
  parameter int AMT_W = SHF_AMT_W,
  localparam int IMM_W = $clog2(W),
  localparam int CW    = $clog2(W) + 1
) (
  input  shift_kind_e      kind,
  input  logic             use_reg,
  input  logic [AMT_W-1:0] amt,
  output logic [CW-1:0]    eff,
  output shf_special_t     spc
);

  localparam logic [CW-1:0]    FULL_EFF = CW'(W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(W);

  logic [IMM_W-1:0] low_n;
  assign low_n = amt[IMM_W-1:0];

  always_comb begin
    eff = '0;
    spc = '0;
    if (!use_reg) begin
      unique case (kind)
        SK_LSL: begin
          if (low_n == '0) spc.hold = 1'b1;
          else             eff = {1'b0, low_n};
        end
        SK_LSR, SK_ASR: eff = (low_n == '0) ? FULL_EFF : {1'b0, low_n};
        SK_ROR: begin
          if (low_n == '0) spc.rrx = 1'b1;
          else             eff = {1'b0, low_n};
        end
        default: eff = '0;
      endcase
    end else if (amt == '0) begin
      spc.hold = 1'b1;
    end else begin
      unique case (kind)
        SK_LSL, SK_LSR: begin
          if (amt > FULL_AMT) spc.zero_all = 1'b1;
          else                eff = CW'(amt);
        end
        SK_ASR:  eff = (amt >= FULL_AMT) ? FULL_EFF : CW'(amt);
        SK_ROR:  eff = (low_n == '0) ? FULL_EFF : {1'b0, low_n};
        default: eff = '0;
      endcase
    end
  end

endmodule

// File: rtl/shf_rshift_log.sv
module shf_rshift_log #(
  parameter int WIDE = 65,
  parameter int SW   = 6
) (
  input  logic [WIDE-1:0] din,
  input  logic [SW-1:0]   sh,
  output logic [WIDE-1:0] dout
);

  logic [WIDE-1:0] stage [0:SW];

  assign stage[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stage[k+1] = sh[k] ? (stage[k] >> (2 ** k)) : stage[k];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W = SHF_W,
  localparam int CW   = $clog2(W) + 1,
  localparam int WIDE = 2 * W + 1
) (
  input  logic [W-1:0]  din,
  input  shift_kind_e   kind,
  input  logic [CW-1:0] eff,
  output logic [W-1:0]  res,
  output logic          cy
);

  logic [W-1:0]    din_rev, body, body_rev;
  logic [WIDE-1:0] wide_in, wide_out;

  always_comb begin
    for (int i = 0; i < W; i++) din_rev[i] = din[W-1-i];
  end

  // Operand sits above a guard bit; the guard catches the last bit shifted out.
  always_comb begin
    unique case (kind)
      SK_LSL:  wide_in = {{W{1'b0}}, din_rev, 1'b0};
      SK_LSR:  wide_in = {{W{1'b0}}, din, 1'b0};
      SK_ASR:  wide_in = {{W{din[W-1]}}, din, 1'b0};
      SK_ROR:  wide_in = {din, din, 1'b0};
      default: wide_in = '0;
    endcase
  end

  shf_rshift_log #(.WIDE(WIDE), .SW(CW)) u_net (
    .din  (wide_in),
    .sh   (eff),
    .dout (wide_out)
  );

  assign body = wide_out[W:1];

  always_comb begin
    for (int i = 0; i < W; i++) body_rev[i] = body[W-1-i];
  end

  assign res = (kind == SK_LSL) ? body_rev : body;
  assign cy  = wide_out[0];

endmodule

// File: rtl/shf_barrel_unit.sv
module shf_barrel_unit
  import shf_pkg::*;
#(
  parameter int W       = SHF_W,
  parameter int AMT_W   = SHF_AMT_W,
  parameter bit REG_OUT = 1'b1,
  localparam int CW = $clog2(W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     opnd_i,
  input  logic [1:0]       kind_i,
  input  logic             use_reg_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);

  shift_kind_e  kind;
  logic [CW-1:0] eff;
  shf_special_t spc;
  logic [W-1:0] core_res, nxt_res;
  logic         core_cy, nxt_cy;

  assign kind = shift_kind_e'(kind_i);

  shf_amt_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
    .kind    (kind),
    .use_reg (use_reg_i),
    .amt     (amt_i),
    .eff     (eff),
    .spc     (spc)
  );

  shf_core #(.W(W)) u_core (
    .din  (opnd_i),
    .kind (kind),
    .eff  (eff),
    .res  (core_res),
    .cy   (core_cy)
  );

  always_comb begin
    if (spc.hold) begin
      nxt_res = opnd_i;
      nxt_cy  = cin_i;
    end else if (spc.rrx) begin
      nxt_res = {cin_i, opnd_i[W-1:1]};
      nxt_cy  = opnd_i[0];
    end else if (spc.zero_all) begin
      nxt_res = '0;
      nxt_cy  = 1'b0;
    end else begin
      nxt_res = core_res;
      nxt_cy  = core_cy;
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        res_o  <= nxt_res;
        cout_o <= nxt_cy;
      end
    end
  end else begin : g_comb
    assign res_o  = nxt_res;
    assign cout_o = nxt_cy;
  end

  // R1
  special_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spc.hold, spc.rrx, spc.zero_all}));

  // R5
  imm_rrx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_reg_i && kind_i == 2'd3 && amt_i[CW-2:0] == '0)
      |-> (nxt_cy == opnd_i[0] && nxt_res == {cin_i, opnd_i[W-1:1]}));

  // R6
  reg_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_reg_i && amt_i == '0) |-> (nxt_res == opnd_i && nxt_cy == cin_i));

  // R9
  reg_logical_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_reg_i && !kind_i[1] && amt_i > AMT_W'(W))
      |-> (nxt_res == '0 && !nxt_cy));

  // R10
  reg_asr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_reg_i && kind_i == 2'd2 && amt_i >= AMT_W'(W))
      |-> (nxt_res == {W{opnd_i[W-1]}} && nxt_cy == opnd_i[W-1]));

  // R11
  reg_ror_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_reg_i && kind_i == 2'd3 && amt_i != '0 && amt_i[CW-2:0] == '0)
      |-> (nxt_res == opnd_i && nxt_cy == opnd_i[W-1]));

endmodule

// File: tb/test_shf_barrel_unit.sv
module test_shf_barrel_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [1:0]  kind_i = '0;
  logic        use_reg_i = 1'b0;
  logic [7:0]  amt_i = '0;
  logic        cin_i = 1'b0;
  logic [31:0] res_o;
  logic        cout_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_barrel_unit i_shf_barrel_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_i    (opnd_i),
    .kind_i    (kind_i),
    .use_reg_i (use_reg_i),
    .amt_i     (amt_i),
    .cin_i     (cin_i),
    .res_o     (res_o),
    .cout_o    (cout_o)
  );

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    return (v >> n) | (v << (32 - n));
  endfunction

  function automatic void model(input logic [31:0] v, input logic [1:0] k,
                                input logic rm, input logic [7:0] a, input logic c,
                                output logic [31:0] r, output logic cy,
                                output string tag);
    int n;
    if (!rm) begin
      n = int'(a[4:0]);
      tag = (n == 0) ? (k == 0 ? "R3" : (k == 3 ? "R5" : "R4")) : "R2";
      if (a[7:5] != 3'b0) tag = {tag, "/R1"};
      case (k)
        2'd0: if (n == 0) begin r = v; cy = c; end
              else begin r = v << n; cy = v[32-n]; end
        2'd1: if (n == 0) begin r = '0; cy = v[31]; end
              else begin r = v >> n; cy = v[n-1]; end
        2'd2: if (n == 0) begin r = {32{v[31]}}; cy = v[31]; end
              else begin r = 32'($signed(v) >>> n); cy = v[n-1]; end
        default: if (n == 0) begin r = {c, v[31:1]}; cy = v[0]; end
              else begin r = rotr(v, n); cy = v[n-1]; end
      endcase
    end else begin
      n = int'(a);
      if (n == 0) begin
        tag = "R6"; r = v; cy = c;
      end else if (k == 2'd3) begin
        n = n % 32;
        if (n == 0) begin tag = "R11"; r = v; cy = v[31]; end
        else begin tag = "R7"; r = rotr(v, n); cy = v[n-1]; end
      end else if (n < 32) begin
        tag = "R7";
        case (k)
          2'd0:    begin r = v << n; cy = v[32-n]; end
          2'd1:    begin r = v >> n; cy = v[n-1]; end
          default: begin r = 32'($signed(v) >>> n); cy = v[n-1]; end
        endcase
      end else if (k == 2'd2) begin
        tag = "R10"; r = {32{v[31]}}; cy = v[31];
      end else if (n == 32) begin
        tag = "R8"; r = '0; cy = (k == 2'd0) ? v[0] : v[31];
      end else begin
        tag = "R9"; r = '0; cy = 1'b0;
      end
    end
  endfunction

  // Drive on a falling edge, one rising edge loads the register (R12), check on the next falling edge.
  task automatic run_case(input logic [31:0] v, input logic [1:0] k, input logic rm,
                          input logic [7:0] a, input logic c);
    logic [31:0] exp_r;
    logic        exp_c;
    string       tag;
    @(negedge clk);
    opnd_i = v; kind_i = k; use_reg_i = rm; amt_i = a; cin_i = c;
    model(v, k, rm, a, c, exp_r, exp_c, tag);
    @(negedge clk);
    n_checks++;
    if (res_o !== exp_r || cout_o !== exp_c) begin
      n_fails++;
      $display("FAIL %s (R12 timing) kind=%0d reg=%0b amt=%0d in=%h cin=%0b: got %h/%0b expected %h/%0b",
               tag, k, rm, a, v, c, res_o, cout_o, exp_r, exp_c);
    end
  endtask

  function automatic logic [7:0] pick_amt();
    case ($urandom % 8)
      0: return 8'd0;
      1: return 8'd1;
      2: return 8'd31;
      3: return 8'd32;
      4: return 8'd33;
      5: return 8'(($urandom % 8) * 32);
      6: return 8'd255;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    int edge_amt [6] = '{0, 1, 31, 32, 33, 255};
    logic [31:0] pat [3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_3C5A};
    void'($urandom(32'h5EED_1234));

    // R12: outputs held at zero in reset with live inputs
    opnd_i = 32'hFFFF_FFFF; kind_i = 2'd3; use_reg_i = 1'b1; amt_i = 8'd5; cin_i = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_o !== 32'h0 || cout_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R12 reset: got %h/%0b expected 00000000/0", res_o, cout_o);
    end
    rst_n = 1'b1;

    // Directed boundaries for every kind and mode (R2..R11)
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 4; k++)
        for (int e = 0; e < 6; e++)
          for (int p = 0; p < 3; p++)
            run_case(pat[p], 2'(k), 1'(m), 8'(edge_amt[e]), 1'(p & 1));

    // R1: immediate mode ignores amt[7:5]
    for (int k = 0; k < 4; k++) begin
      run_case(32'hDEAD_BEEF, 2'(k), 1'b0, 8'hE0, 1'b1);
      run_case(32'h1234_5678, 2'(k), 1'b0, 8'hA7, 1'b0);
    end

    // Random mix
    for (int i = 0; i < 3000; i++)
      run_case($urandom, 2'($urandom), 1'($urandom), pick_amt(), 1'($urandom));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule